// File: doc/BRIEF.md
# Fractional Prescaler Baud Generator

This block turns a fast reference clock into the bit-rate tick of a serial port. It has two stages. An integer prescaler counts reference cycles and fires an advance strobe once every (scale+1) cycles. On each strobe, a 17-bit phase accumulator adds a 16-bit step value. Every carry out of the accumulator's top bit produces one baud tick, and the accumulator keeps the remainder. The average tick rate is therefore clk × step / ((scale+1) × 2^17). Because the remainder is kept, the fractional part of the division is spread evenly over time instead of being lost.

Software sets both values with a single 32-bit configuration write. Every configuration write, and every cycle with the enable input low, clears both counters. The first tick after a write or after enable rises therefore lands at a fixed, predictable time. The intended sequence is to drop enable, write the configuration, and raise enable again.

Top module: `frac_baud_gen`

## Requirements
- R1: Over any run of N enabled cycles that follow a clear, with no write in between, the number of ticks equals floor(floor(N/(scale+1)) × step / 2^17).
- R2: In the configuration word, bits [23:16] are the scale and bits [15:0] are the step. Bits [31:24] have no effect on the output.
- R3: With scale = 0 the accumulator advances on every enabled cycle. For example, step = 0x8000 gives a tick on every 4th cycle.
- R4: With scale = s the accumulator advances once every s+1 enabled cycles. For example, scale = 3 with step = 0x8000 gives the first tick on the 16th edge after a clear.
- R5: baud_tick is high for only one cycle at a time. This also holds at the fastest setting, scale = 0 with step = 0xFFFF, which gives 499 ticks in 1000 cycles after a clear.
- R6: A configuration write clears the prescaler and the accumulator. The first tick then comes ceil(2^17/step) × (scale+1) rising edges after the write edge, even when the write lands in the middle of a run.
- R7: With step = 0, no tick is ever produced.
- R8: While enable is low, no tick is produced and both counters stay at zero. The first tick after enable rises follows the same timing as in R6, counting the first enabled edge as edge 1.
- R9: During and after synchronous reset, baud_tick is 0, and the configuration reads as scale = 0 and step = 0. No ticks occur until the block is written.
- R10: Every output cycle matches a cycle-accurate model of the two stages under random configurations and random enable patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when high; holds both counters at zero when low |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | 32 | Configuration word: scale in [23:16], step in [15:0] |
| baud_tick | output | 1 | Registered single-cycle baud tick |

## Verification
The assertions rely on the step being narrower than half the accumulator range. This is what makes two ticks in a row impossible. They also rely on the scale changing only through a write, which resets the prescaler count at the same edge. The stimulus changes the configuration only through cfg_we and drives random 16-bit steps, including zero and 0xFFFF. The random scales are kept small so that each run segment contains many advances, and enable is toggled at random within each segment.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned CFG_W_D     = 32;
  localparam int unsigned SCALE_W_D   = 8;
  localparam int unsigned STEP_W_D    = 16;
  localparam int unsigned ACC_W_D     = 17;
  localparam int unsigned SCALE_LSB_D = 16;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int unsigned CFG_W     = baud_pkg::CFG_W_D,
  parameter int unsigned SCALE_W   = baud_pkg::SCALE_W_D,
  parameter int unsigned STEP_W    = baud_pkg::STEP_W_D,
  parameter int unsigned SCALE_LSB = baud_pkg::SCALE_LSB_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CFG_W-1:0]   wdata,
  output logic [SCALE_W-1:0] scale_q,
  output logic [STEP_W-1:0]  step_q
);
  localparam int unsigned SCALE_MSB = SCALE_LSB + SCALE_W - 1;

  logic unused_hi;
  assign unused_hi = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q <= '0;
      step_q  <= '0;
    end else if (we) begin
      scale_q <= wdata[SCALE_MSB:SCALE_LSB];
      step_q  <= wdata[STEP_W-1:0];
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned SCALE_W = baud_pkg::SCALE_W_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  output logic               adv
);
  logic [SCALE_W-1:0] cnt;

  assign adv = run && (cnt == scale);

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (adv)       cnt <= '0;
    else if (run)       cnt <= cnt + 1'b1;
  end

  // R4: the count never passes the reload value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= scale);
  // R8: a clear leaves the prescaler at zero
  p_clear_hold_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned STEP_W = baud_pkg::STEP_W_D,
  parameter int unsigned ACC_W  = baud_pkg::ACC_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic              tick
);
  localparam int unsigned PAD_W = ACC_W + 1 - STEP_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {{PAD_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (adv) begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end else begin
      tick <= 1'b0;
    end
  end

  // R5: the tick never lasts two cycles
  p_single_tick_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R7: zero step never carries
  p_zero_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> !tick);
  // R6: a clear empties the accumulator and drops the tick
  p_clear_acc_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == '0 && !tick));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned CFG_W     = baud_pkg::CFG_W_D,
  parameter int unsigned SCALE_W   = baud_pkg::SCALE_W_D,
  parameter int unsigned STEP_W    = baud_pkg::STEP_W_D,
  parameter int unsigned ACC_W     = baud_pkg::ACC_W_D,
  parameter int unsigned SCALE_LSB = baud_pkg::SCALE_LSB_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             baud_tick
);
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;
  logic               clear, run, adv;

  assign clear = cfg_we || !enable;
  assign run   = enable && !cfg_we;

  baud_cfg_reg #(.CFG_W(CFG_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W),
                 .SCALE_LSB(SCALE_LSB)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .scale_q(scale_q), .step_q(step_q));

  baud_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .clear(clear), .run(run),
    .scale(scale_q), .adv(adv));

  baud_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clear(clear), .adv(adv),
    .step(step_q), .tick(baud_tick));

  // R8: a disabled cycle is followed by a quiet output
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !baud_tick);
  // R9: reset leaves the output low
  p_reset_r9: assert property (@(posedge clk)
    rst |=> !baud_tick);
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst, enable, cfg_we;
  logic [31:0] cfg_wdata;
  logic        baud_tick;

  int checks = 0, fails = 0, tick_seen = 0;
  logic [7:0]  m_scale;
  logic [15:0] m_step;
  logic [7:0]  m_cnt;
  logic [16:0] m_acc;
  logic        m_tick;

  always #5 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .baud_tick(baud_tick));

  // cycle model built from the requirement text
  always @(posedge clk) begin
    logic [17:0] s;
    if (rst) begin
      m_scale <= 0; m_step <= 0; m_cnt <= 0; m_acc <= 0; m_tick <= 0;
    end else if (cfg_we || !enable) begin
      if (cfg_we) begin
        m_scale <= cfg_wdata[23:16];
        m_step  <= cfg_wdata[15:0];
      end
      m_cnt <= 0; m_acc <= 0; m_tick <= 0;
    end else if (m_cnt == m_scale) begin
      s = {1'b0, m_acc} + {2'b0, m_step};
      m_cnt <= 0; m_acc <= s[16:0]; m_tick <= s[17];
    end else begin
      m_cnt <= m_cnt + 8'd1; m_tick <= 0;
    end
  end

  function automatic int first_edge(int sc, int st);
    return ((131072 + st - 1) / st) * (sc + 1);
  endfunction

  function automatic int ticks_in(int n, int sc, int st);
    longint adv = n / (sc + 1);
    return int'((adv * st) / 131072);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic one_cycle();
    @(posedge clk);
    @(negedge clk);
    if (baud_tick) tick_seen++;
    chk(baud_tick == m_tick, "R10 model", baud_tick, m_tick);
  endtask

  task automatic write_cfg(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    one_cycle();
    cfg_we = 1'b0;
  endtask

  task automatic find_first(int limit, output int at);
    at = -1;
    for (int i = 1; i <= limit; i++) begin
      one_cycle();
      if (baud_tick && at < 0) at = i;
      if (at >= 0) break;
    end
  endtask

  task automatic run_n(int n, output int cnt);
    tick_seen = 0;
    for (int i = 0; i < n; i++) one_cycle();
    cnt = tick_seen;
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int at, cnt;
    void'($urandom(32'd4711));
    rst = 1'b1; enable = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(baud_tick == 1'b0, "R9 reset output", baud_tick, 0);
    rst = 1'b0; enable = 1'b1;
    run_n(100, cnt);
    chk(cnt == 0, "R9 unwritten config idle", cnt, 0);

    write_cfg(32'h0000_0000);
    run_n(300, cnt);
    chk(cnt == 0, "R7 zero step", cnt, 0);

    write_cfg(32'h0000_8000);
    find_first(50, at);
    chk(at == 4, "R3 scale0 first tick", at, 4);
    write_cfg(32'h0000_8000);
    run_n(40, cnt);
    chk(cnt == 10, "R3 scale0 period", cnt, 10);

    write_cfg(32'h0003_8000);
    find_first(100, at);
    chk(at == first_edge(3, 32768), "R4 prescale first tick", at, first_edge(3, 32768));

    write_cfg(32'hAB01_8000);
    find_first(100, at);
    chk(at == 8, "R2 field positions, upper byte ignored", at, 8);

    write_cfg(32'h0002_0BB8);
    run_n(30000, cnt);
    chk(cnt == ticks_in(30000, 2, 3000), "R1 fractional rate", cnt, ticks_in(30000, 2, 3000));

    write_cfg(32'h0001_4000);
    run_n(5, cnt);
    write_cfg(32'h0001_4000);
    find_first(100, at);
    chk(at == first_edge(1, 16384), "R6 rewrite mid-run restarts", at, first_edge(1, 16384));

    enable = 1'b0;
    run_n(60, cnt);
    chk(cnt == 0, "R8 disabled quiet", cnt, 0);
    enable = 1'b1;
    find_first(100, at);
    chk(at == first_edge(1, 16384), "R8 re-enable timing", at, first_edge(1, 16384));

    write_cfg(32'h0000_FFFF);
    tick_seen = 0;
    begin
      int dbl = 0; logic prev = 1'b0;
      for (int i = 0; i < 1000; i++) begin
        one_cycle();
        if (prev && baud_tick) dbl++;
        prev = baud_tick;
      end
      chk(dbl == 0, "R5 no back-to-back ticks", dbl, 0);
      chk(tick_seen == 499, "R5 max rate count", tick_seen, 499);
    end

    for (int seg = 0; seg < 30; seg++) begin
      logic [31:0] w;
      w = {$urandom_range(0, 255) & 32'hFF, 8'd0, 16'd0};
      w = {w[31:24], 8'($urandom_range(0, 7)), 16'($urandom)};
      if (seg == 3) w[15:0] = 16'h0000;
      if (seg == 4) w[15:0] = 16'hFFFF;
      write_cfg(w);
      for (int i = 0; i < 600; i++) begin
        enable = ($urandom_range(0, 19) != 0);
        one_cycle();
      end
      enable = 1'b1;
    end

    rst = 1'b1;
    one_cycle();
    rst = 1'b0;
    run_n(50, cnt);
    chk(cnt == 0, "R9 reset clears config", cnt, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule